// File: doc/BRIEF.md
# Configurable Asynchronous Serial Engine with Error Actions

This block sends and receives asynchronous serial characters of 5 to 8 data bits. Parity is optional and can be odd or even. The transmitter can also hold the line low to send a break. Bit timing comes from an enable pulse supplied at sixteen times the bit rate.

Received characters are presented as a 16-bit word. The character sits in the low byte. The high byte carries error flags when flag reporting is enabled, and reads as zero when it is not.

When a framing error or a break is received, the engine can ask the host to halt or to restart. It does this with single-cycle request pulses. A maintenance bit feeds the transmit line back into the receiver and suppresses both requests. Characters enter and leave through valid/ready streams:

- The transmit side accepts a byte only while `tx_ready` is high, that is, while no frame is in progress. A held `tx_valid` simply waits.
- The receive side holds `rx_valid` and the word until `rx_ready` is seen. It has no deeper storage: a character that completes while the previous one is still pending replaces it and marks an overrun.

Top module: `sercom_engine`

## Requirements
- R1: `cfg_len` selects the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Received bits above the selected length read 0 in `rx_word[7:0]`.
- R2: An idle line is high. A frame is a low start bit, then the data bits LSB first, then the parity bit when enabled, then one high stop bit. Each bit lasts 16 `tick16` pulses.
- R3: When `cfg_par_en` is 1, the transmitter inserts parity and the receiver checks it. The parity is even when `cfg_par_odd` is 0 and odd when it is 1. A mismatch sets `rx_word[12]`.
- R4: While `cfg_brk_en` and `brk_cmd` are both 1, `sout` is 0. When `cfg_brk_en` is 0, `brk_cmd` has no effect on `sout`.
- R5: A stop bit sampled low sets the framing flag `rx_word[13]`.
- R6: When `cfg_halt_en` is 1 and maintenance is off, a received framing error pulses `halt_req` for one cycle. The pulse comes in the cycle the character is delivered.
- R7: When `cfg_boot_en` is 1 and maintenance is off, a received framing error or break pulses `boot_req` for one cycle. A break is all-zero data with a low stop bit. The pulse comes in the cycle the character is delivered.
- R8: The flag byte of `rx_word` is laid out as follows:
  - bit 15 is set when any flag is set;
  - bit 14 is overrun;
  - bit 13 is framing;
  - bit 12 is parity;
  - bits 11:8 are 0.

  Each new character replaces the flags. When `cfg_eflag_en` is 0, `rx_word[15:8]` reads 0.
- R9: If a character completes while `rx_valid` is high and no `rx_ready` handshake happens in that cycle, the new data replaces the old and the overrun flag is set.
- R10: `maint_wr` loads `maint_din` into the maintenance bit (`maint_on`) only when `cfg_maint_en` is 1. While the bit is set, the receiver listens to `sout` and ignores `sin`.
- R11: `tx_ready` is high only when no frame is being sent. A byte is taken on a cycle with `tx_valid` and `tx_ready` both high, and `tx_ready` is low on the next cycle.
- R12: `rx_valid` stays high, with `rx_word` unchanged, until a cycle with `rx_ready` high, unless a new character arrives.
- R13: After reset, the block is in this state:
  - `sout` is 1 and `tx_ready` is 1;
  - `rx_valid` is 0;
  - `halt_req`, `boot_req` and `maint_on` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Enable at 16x the bit rate |
| cfg_len | input | 2 | Data length code |
| cfg_par_en | input | 1 | Parity on |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_brk_en | input | 1 | Allows break transmission |
| cfg_halt_en | input | 1 | Halt request on framing error |
| cfg_boot_en | input | 1 | Restart request on framing error or break |
| cfg_eflag_en | input | 1 | Shows flags in the high byte |
| cfg_maint_en | input | 1 | Allows writes to the maintenance bit |
| brk_cmd | input | 1 | Break command |
| maint_wr | input | 1 | Maintenance bit write strobe |
| maint_din | input | 1 | Maintenance bit write value |
| maint_on | output | 1 | Maintenance bit |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Transmitter can take a byte |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received word valid |
| rx_ready | input | 1 | Consumer takes the word |
| rx_word | output | 16 | Flags (high byte) and data (low byte) |
| sin | input | 1 | Serial input |
| sout | output | 1 | Serial output |
| halt_req | output | 1 | Halt request pulse |
| boot_req | output | 1 | Restart request pulse |

## Verification
The checker watches the following on every cycle:
- the break forcing and idle level of `sout`;
- that `tx_ready` drops after each accepted byte;
- that `rx_valid` holds until it is consumed;
- that the flag byte stays zero while flags are disabled;
- that request pulses last one cycle, come only with a delivered word, and never come in maintenance mode;
- that maintenance writes are blocked while the write enable is off.

Some behaviour can only be shown by the bench's scenarios:
- the bit-level framing for each length and parity choice, shown by loopback round trips;
- the parity, framing, break and overrun flag values;
- the choice between halt and restart actions;
- that `sin` is ignored in loopback;
- that the receiver does not re-trigger on a line held low.

// File: rtl/sercom_pkg.sv
package sercom_pkg;
  localparam int DATA_W = 8;
  localparam int FRAME_W = 12;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_HOLD
  } rx_state_t;

  typedef struct packed {
    logic any;
    logic ovr;
    logic fe;
    logic pe;
  } rx_flags_t;
endpackage

// File: rtl/sercom_tx.sv
module sercom_tx #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       line
);
  import sercom_pkg::*;
  localparam int CW = $clog2(OSR);

  logic               busy;
  logic [FRAME_W-1:0] sh;
  logic [FRAME_W-1:0] frame;
  logic [3:0]         left;
  logic [3:0]         nbits;
  logic [3:0]         nd;
  logic [CW-1:0]      tcnt;
  logic [7:0]         dm;

  // Build the frame: start bit low, data LSB first, optional parity, stop bit high.
  always_comb begin
    nd    = 4'd5 + {2'b00, len};
    dm    = in_data & (8'hFF >> (2'd3 - len));
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(nd)) frame[i+1] = dm[i];
    end
    if (par_en) frame[nd+4'd1] = ^dm ^ par_odd;
    nbits = nd + 4'd2 + {3'b000, par_en};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      left <= '0;
      tcnt <= '0;
    end else if (!busy && in_valid) begin
      busy <= 1'b1;
      sh   <= frame;
      left <= nbits;
      tcnt <= '0;
    end else if (busy && tick) begin
      if (tcnt == CW'(OSR - 1)) begin
        tcnt <= '0;
        sh   <= {1'b1, sh[FRAME_W-1:1]};
        left <= left - 4'd1;
        if (left == 4'd1) busy <= 1'b0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign in_ready = !busy;
  assign line     = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/sercom_rx.sv
module sercom_rx #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rin,
  input  logic [1:0] len,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       done,
  output logic [7:0] data,
  output logic       pe,
  output logic       fe,
  output logic       brk
);
  import sercom_pkg::*;
  localparam int CW = $clog2(OSR);

  rx_state_t     st;
  logic [8:0]    sh;
  logic [3:0]    idx;
  logic [3:0]    nd;
  logic [3:0]    nsamp;
  logic [7:0]    dsh;
  logic [CW-1:0] tcnt;

  always_comb begin
    nd    = 4'd5 + {2'b00, len};
    nsamp = nd + {3'b000, par_en} + 4'd1;
    dsh   = sh[7:0] & (8'hFF >> (2'd3 - len));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      sh   <= '0;
      idx  <= '0;
      tcnt <= '0;
      done <= 1'b0;
      data <= '0;
      pe   <= 1'b0;
      fe   <= 1'b0;
      brk  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        RX_IDLE: begin
          if (tick && !rin) begin
            st   <= RX_START;
            tcnt <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            // Confirm the start bit at its middle.
            if (tcnt == CW'(OSR/2 - 1)) begin
              tcnt <= '0;
              idx  <= '0;
              st   <= rin ? RX_IDLE : RX_BITS;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        RX_BITS: begin
          if (tick) begin
            if (tcnt == CW'(OSR - 1)) begin
              tcnt <= '0;
              if (idx == nsamp - 4'd1) begin
                // This sample is the stop bit.
                done <= 1'b1;
                data <= dsh;
                pe   <= par_en & (^dsh ^ sh[nd] ^ par_odd);
                fe   <= !rin;
                brk  <= !rin && (dsh == 8'h00);
                st   <= rin ? RX_IDLE : RX_HOLD;
              end else begin
                sh[idx] <= rin;
                idx     <= idx + 4'd1;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        default: begin
          // Line still low after a bad frame: wait for it to go high before re-arming.
          if (rin) st <= RX_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/sercom_engine.sv
module sercom_engine #(
  parameter int OSR = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick16,
  input  logic [1:0]  cfg_len,
  input  logic        cfg_par_en,
  input  logic        cfg_par_odd,
  input  logic        cfg_brk_en,
  input  logic        cfg_halt_en,
  input  logic        cfg_boot_en,
  input  logic        cfg_eflag_en,
  input  logic        cfg_maint_en,
  input  logic        brk_cmd,
  input  logic        maint_wr,
  input  logic        maint_din,
  output logic        maint_on,
  input  logic        tx_valid,
  output logic        tx_ready,
  input  logic [7:0]  tx_data,
  output logic        rx_valid,
  input  logic        rx_ready,
  output logic [15:0] rx_word,
  input  logic        sin,
  output logic        sout,
  output logic        halt_req,
  output logic        boot_req
);
  import sercom_pkg::*;

  logic       tx_line;
  logic [1:0] sync;
  logic       rx_done;
  logic [7:0] rx_d;
  logic       rx_pe;
  logic       rx_fe;
  logic       rx_brk;
  logic [7:0] hold_data;
  rx_flags_t  flags;

  sercom_tx #(.OSR(OSR)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .len      (cfg_len),
    .par_en   (cfg_par_en),
    .par_odd  (cfg_par_odd),
    .in_valid (tx_valid),
    .in_data  (tx_data),
    .in_ready (tx_ready),
    .line     (tx_line)
  );

  assign sout = tx_line & ~(cfg_brk_en & brk_cmd);

  // Loopback source selection, then a two-stage synchronizer.
  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], maint_on ? sout : sin};
  end

  sercom_rx #(.OSR(OSR)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick16),
    .rin     (sync[1]),
    .len     (cfg_len),
    .par_en  (cfg_par_en),
    .par_odd (cfg_par_odd),
    .done    (rx_done),
    .data    (rx_d),
    .pe      (rx_pe),
    .fe      (rx_fe),
    .brk     (rx_brk)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid  <= 1'b0;
      hold_data <= '0;
      flags     <= '0;
      halt_req  <= 1'b0;
      boot_req  <= 1'b0;
      maint_on  <= 1'b0;
    end else begin
      if (maint_wr && cfg_maint_en) maint_on <= maint_din;
      halt_req <= rx_done && rx_fe && cfg_halt_en && !maint_on;
      boot_req <= rx_done && (rx_fe || rx_brk) && cfg_boot_en && !maint_on;
      if (rx_done) begin
        rx_valid  <= 1'b1;
        hold_data <= rx_d;
        flags.ovr <= rx_valid && !rx_ready;
        flags.fe  <= rx_fe;
        flags.pe  <= rx_pe;
        flags.any <= (rx_valid && !rx_ready) || rx_fe || rx_pe;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  assign rx_word = {cfg_eflag_en ? {flags, 4'b0000} : 8'h00, hold_data};
endmodule

// File: rtl/sercom_chk.sv
module sercom_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_brk_en,
  input logic        cfg_eflag_en,
  input logic        cfg_maint_en,
  input logic        brk_cmd,
  input logic        maint_wr,
  input logic        maint_on,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic [15:0] rx_word,
  input logic        sout,
  input logic        halt_req,
  input logic        boot_req
);
  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready && !(cfg_brk_en && brk_cmd) |-> sout);

  assert_break_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_brk_en && brk_cmd |-> !sout);

  assert_halt_with_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> rx_valid && !maint_on);

  assert_halt_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> !halt_req);

  assert_boot_with_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    boot_req |-> rx_valid && !maint_on);

  assert_boot_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    boot_req |=> !boot_req);

  assert_flags_hidden_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_eflag_en |-> rx_word[15:8] == 8'h00);

  assert_maint_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    maint_wr && !cfg_maint_en |=> $stable(maint_on));

  assert_tx_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);

  assert_rx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid);
endmodule

bind sercom_engine sercom_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_brk_en   (cfg_brk_en),
  .cfg_eflag_en (cfg_eflag_en),
  .cfg_maint_en (cfg_maint_en),
  .brk_cmd      (brk_cmd),
  .maint_wr     (maint_wr),
  .maint_on     (maint_on),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .rx_valid     (rx_valid),
  .rx_ready     (rx_ready),
  .rx_word      (rx_word),
  .sout         (sout),
  .halt_req     (halt_req),
  .boot_req     (boot_req)
);

// File: tb/sercom_engine_test.sv
module sercom_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick16 = 1'b1;
  logic [1:0]  cfg_len = 2'b11;
  logic        cfg_par_en = 1'b0;
  logic        cfg_par_odd = 1'b0;
  logic        cfg_brk_en = 1'b0;
  logic        cfg_halt_en = 1'b0;
  logic        cfg_boot_en = 1'b0;
  logic        cfg_eflag_en = 1'b1;
  logic        cfg_maint_en = 1'b0;
  logic        brk_cmd = 1'b0;
  logic        maint_wr = 1'b0;
  logic        maint_din = 1'b0;
  logic        maint_on;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [7:0]  tx_data = 8'h00;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic [15:0] rx_word;
  logic        sin = 1'b1;
  logic        sout;
  logic        halt_req;
  logic        boot_req;

  int n_chk = 0;
  int n_fail = 0;
  int halt_cnt = 0;
  int boot_cnt = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  sercom_engine uut (.*);

  // Fields: {len[1:0], par_en, par_odd, data[7:0], expected low byte[7:0]}
  localparam logic [19:0] VEC [7] = '{
    {2'b00, 1'b0, 1'b0, 8'hFF, 8'h1F},
    {2'b01, 1'b1, 1'b0, 8'hA5, 8'h25},
    {2'b10, 1'b1, 1'b1, 8'h5A, 8'h5A},
    {2'b11, 1'b0, 1'b0, 8'hC3, 8'hC3},
    {2'b11, 1'b1, 1'b0, 8'h81, 8'h81},
    {2'b11, 1'b1, 1'b1, 8'h00, 8'h00},
    {2'b10, 1'b0, 1'b0, 8'hFF, 8'h7F}
  };

  always @(negedge clk) begin
    if (halt_req) halt_cnt++;
    if (boot_req) boot_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_rx(output bit got);
    got = 1'b0;
    for (int i = 0; i < 600; i++) begin
      if (rx_valid) begin
        got = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic pop();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic drive_frame(input logic [11:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      sin = bits[i];
      repeat (16) @(negedge clk);
    end
    sin = 1'b1;
    repeat (32) @(negedge clk);
  endtask

  task automatic write_maint(input logic v);
    maint_wr = 1'b1;
    maint_din = v;
    @(negedge clk);
    maint_wr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    bit got;
    repeat (5) @(negedge clk);
    // R13 reset state
    chk(sout == 1'b1, "R13 sout", {15'd0, sout}, 16'd1);
    chk(tx_ready == 1'b1, "R13 tx_ready", {15'd0, tx_ready}, 16'd1);
    chk({rx_valid, halt_req, boot_req, maint_on} == 4'b0, "R13 outputs low",
        {12'd0, rx_valid, halt_req, boot_req, maint_on}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: write blocked while maintenance enable is off
    write_maint(1'b1);
    chk(maint_on == 1'b0, "R10 locked write", {15'd0, maint_on}, 16'd0);
    cfg_maint_en = 1'b1;
    write_maint(1'b1);
    chk(maint_on == 1'b1, "R10 enabled write", {15'd0, maint_on}, 16'd1);

    // Loopback round trips; sin held low to show it is ignored (R10).
    sin = 1'b0;
    for (int v = 0; v < 7; v++) begin
      cfg_len = VEC[v][19:18];
      cfg_par_en = VEC[v][17];
      cfg_par_odd = VEC[v][16];
      while (!tx_ready) @(negedge clk);
      tx_data = VEC[v][15:8];
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      chk(tx_ready == 1'b0, "R11 busy after accept", {15'd0, tx_ready}, 16'd0);
      chk(sout == 1'b0, "R2 start bit", {15'd0, sout}, 16'd0);
      wait_rx(got);
      chk(got && rx_word == {8'h00, VEC[v][7:0]}, "R1 R3 loopback word", rx_word, {8'h00, VEC[v][7:0]});
      pop();
    end
    repeat (40) @(negedge clk);
    chk(rx_valid == 1'b0, "R10 sin ignored in loopback", {15'd0, rx_valid}, 16'd0);
    sin = 1'b1;

    // R4: break ignored when not enabled
    cfg_len = 2'b11; cfg_par_en = 1'b0;
    brk_cmd = 1'b1;
    repeat (5) @(negedge clk);
    chk(sout == 1'b1, "R4 break disabled", {15'd0, sout}, 16'd1);
    repeat (250) @(negedge clk);
    chk(rx_valid == 1'b0, "R4 no frame from disabled break", {15'd0, rx_valid}, 16'd0);

    // R4 R6 R7 R10: break in loopback sets flags, requests suppressed
    cfg_brk_en = 1'b1; cfg_halt_en = 1'b1; cfg_boot_en = 1'b1;
    halt_cnt = 0; boot_cnt = 0;
    @(negedge clk);
    chk(sout == 1'b0, "R4 break drives low", {15'd0, sout}, 16'd0);
    repeat (220) @(negedge clk);
    brk_cmd = 1'b0;
    repeat (40) @(negedge clk);
    wait_rx(got);
    chk(got && rx_word == 16'hA000, "R5 break word in loopback", rx_word, 16'hA000);
    chk(halt_cnt == 0 && boot_cnt == 0, "R6 R7 suppressed in maintenance",
        16'(halt_cnt + boot_cnt), 16'd0);
    pop();
    write_maint(1'b0);
    cfg_brk_en = 1'b0;

    // R3: parity error, flags visible
    cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_halt_en = 1'b0; cfg_boot_en = 1'b0;
    drive_frame({1'b1, 1'b0, 8'h01, 1'b0}, 11);
    wait_rx(got);
    chk(got && rx_word == 16'h9001, "R3 parity error flag", rx_word, 16'h9001);
    pop();
    // R8: same error with flags hidden
    cfg_eflag_en = 1'b0;
    drive_frame({1'b1, 1'b0, 8'h01, 1'b0}, 11);
    wait_rx(got);
    chk(got && rx_word == 16'h0001, "R8 flags hidden", rx_word, 16'h0001);
    pop();
    cfg_eflag_en = 1'b1;
    cfg_par_en = 1'b0;

    // R5 R6: framing error requests halt only
    cfg_halt_en = 1'b1; cfg_boot_en = 1'b0;
    halt_cnt = 0; boot_cnt = 0;
    drive_frame({2'b00, 1'b0, 8'h41, 1'b0}, 10);
    wait_rx(got);
    chk(got && rx_word == 16'hA041, "R5 framing flag", rx_word, 16'hA041);
    chk(halt_cnt == 1 && boot_cnt == 0, "R6 halt pulse", 16'(halt_cnt * 16 + boot_cnt), 16'h0010);
    pop();

    // R7: break requests restart; line kept low afterwards must not re-trigger
    cfg_halt_en = 1'b0; cfg_boot_en = 1'b1;
    halt_cnt = 0; boot_cnt = 0;
    drive_frame(12'h000, 12);
    wait_rx(got);
    chk(got && rx_word == 16'hA000, "R7 break word", rx_word, 16'hA000);
    chk(halt_cnt == 0 && boot_cnt == 1, "R7 restart pulse", 16'(halt_cnt * 16 + boot_cnt), 16'h0001);
    pop();
    repeat (40) @(negedge clk);
    chk(rx_valid == 1'b0, "R7 no re-trigger on held low", {15'd0, rx_valid}, 16'd0);
    cfg_boot_en = 1'b0;

    // R9 R12: overrun
    drive_frame({1'b1, 8'h11, 1'b0}, 10);
    chk(rx_valid == 1'b1 && rx_word == 16'h0011, "R12 word held", rx_word, 16'h0011);
    repeat (50) @(negedge clk);
    chk(rx_valid == 1'b1 && rx_word == 16'h0011, "R12 still held", rx_word, 16'h0011);
    drive_frame({1'b1, 8'h22, 1'b0}, 10);
    chk(rx_valid == 1'b1 && rx_word == 16'hC022, "R9 overrun flag", rx_word, 16'hC022);
    pop();
    chk(rx_valid == 1'b0, "R12 consumed", {15'd0, rx_valid}, 16'd0);

    done_flag = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(negedge clk);
      if (done_flag) break;
    end
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule